// File: doc/BRIEF.md
# Optical Drive Spindle State Controller

This block tracks the motor and readiness state of an optical drive with one cycle-count timer. When media is loaded, the drive goes through a settle period and a spin-up period before it reaches the spinning state, where media access is allowed. A media access command that arrives while the drive is spun down starts a new spin-up. Status, sense and mode commands never wake the motor.

While the drive spins, every sector that is completed into the sector buffer reloads an inactivity countdown. The countdown is not reloaded when a command starts. When the countdown runs out, the motor stops, and the next media access must go through spin-up again. The command logic samples `not_ready_o` in the cycle in which it presents a command. A high value tells it to fail that command with a not-ready condition.

All three timeouts are parameters given in clock cycles. The spin-down default equals ten seconds at 50 MHz.

Top module: `spindle_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the drive spun down with no media. `ready_o` and `spinning_o` are low, and a media access command right after reset is reported not ready.
- R2: With no media present, a media access command raises `not_ready_o` in its own cycle and does not start the motor.
- R3: A `media_insert_i` pulse in any state enters the settle state. For the next INSERT_CYC cycles `spinning_o` and `ready_o` stay low, and after that spin-up begins.
- R4: Spin-up holds `spinning_o` high and `ready_o` low for SPINUP_CYC cycles, after which `ready_o` goes high.
- R5: During settle or spin-up, a media access command raises `not_ready_o` in its own cycle and does not change the state.
- R6: Opcodes 0x00, 0x03, 0x15, 0x1A, 0x55 and 0x5A are non-media commands. They never raise `not_ready_o` and never start the motor.
- R7: A media access command (any other opcode) arriving while the drive is spun down with media present is reported not ready in its own cycle. `spinning_o` is high from the next cycle on.
- R8: While `ready_o` is high, commands are never reported not ready, and they do not reload the inactivity countdown. The drive stops SPINDOWN_CYC cycles after it entered the spinning state unless a sector completes.
- R9: A `sector_done_i` pulse while spinning keeps `ready_o` high for exactly SPINDOWN_CYC more cycles. After that the drive returns to spun down with `spinning_o` low.
- R10: `sector_done_i` outside the spinning state has no effect.
- R11: When `media_insert_i` arrives in the same cycle as a sector pulse or a command, the insertion wins and the drive enters settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| media_insert_i | input | 1 | One-cycle pulse: new media loaded |
| cmd_valid_i | input | 1 | One-cycle strobe: new command presented |
| cmd_opcode_i | input | 8 | Opcode of the presented command |
| sector_done_i | input | 1 | One-cycle pulse: a sector reached the buffer |
| ready_o | output | 1 | Spindle at speed, media access allowed |
| spinning_o | output | 1 | Motor on (spin-up or spinning) |
| not_ready_o | output | 1 | Current command must fail as not ready |

## Verification
The bench counts the exact cycle in which each timeout expires. An off-by-one timer therefore shows up as `ready_o` that is early, late, or held one cycle too long.

It issues mode and sense opcodes against a stopped drive that has media. A decoder that treated any of them as media access would start the motor, and `spinning_o` would rise.

It sends a stream of commands with no sectors to a spinning drive. A design that re-armed the countdown at command start would keep the drive spinning past its window.

It collides an insertion with a sector pulse. A design with the wrong priority would stay ready instead of dropping into settle.

// File: rtl/spindle_ctrl.sv
module spindle_ctrl #(
  parameter int unsigned INSERT_CYC   = 25_000_000,
  parameter int unsigned SPINUP_CYC   = 50_000_000,
  parameter int unsigned SPINDOWN_CYC = 500_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       media_insert_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_opcode_i,
  input  logic       sector_done_i,
  output logic       ready_o,
  output logic       spinning_o,
  output logic       not_ready_o
);
  localparam int unsigned MAX_A  = (INSERT_CYC > SPINUP_CYC) ? INSERT_CYC : SPINUP_CYC;
  localparam int unsigned MAX_T  = (MAX_A > SPINDOWN_CYC) ? MAX_A : SPINDOWN_CYC;
  localparam int unsigned CNT_W  = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] INS_LOAD  = CNT_W'(INSERT_CYC - 1);
  localparam logic [CNT_W-1:0] UP_LOAD   = CNT_W'(SPINUP_CYC - 1);
  localparam logic [CNT_W-1:0] DOWN_LOAD = CNT_W'(SPINDOWN_CYC - 1);

  typedef enum logic [1:0] {ST_DOWN, ST_SETTLE, ST_SPINUP, ST_SPIN} spin_state_e;

  spin_state_e      state;
  logic             media;
  logic [CNT_W-1:0] timer;
  logic             media_cmd;
  logic             expired;

  always_comb begin
    case (cmd_opcode_i)
      8'h00, 8'h03, 8'h15, 8'h1A, 8'h55, 8'h5A: media_cmd = 1'b0;
      default:                                  media_cmd = 1'b1;
    endcase
  end

  assign expired = (timer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_DOWN;
      media <= 1'b0;
      timer <= '0;
    end else if (media_insert_i) begin
      state <= ST_SETTLE;
      media <= 1'b1;
      timer <= INS_LOAD;
    end else begin
      case (state)
        ST_DOWN: begin
          if (cmd_valid_i && media_cmd && media) begin
            state <= ST_SPINUP;
            timer <= UP_LOAD;
          end
        end
        ST_SETTLE: begin
          if (expired) begin
            state <= ST_SPINUP;
            timer <= UP_LOAD;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_SPINUP: begin
          if (expired) begin
            state <= ST_SPIN;
            timer <= DOWN_LOAD;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: begin
          if (sector_done_i) timer <= DOWN_LOAD;
          else if (expired)  state <= ST_DOWN;
          else               timer <= timer - 1'b1;
        end
      endcase
    end
  end

  assign ready_o     = (state == ST_SPIN);
  assign spinning_o  = (state == ST_SPIN) || (state == ST_SPINUP);
  assign not_ready_o = cmd_valid_i && media_cmd && (state != ST_SPIN);
endmodule

// File: rtl/spindle_ctrl_chk.sv
module spindle_ctrl_chk #(
  parameter int unsigned SPINDOWN_CYC = 500_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       media_insert_i,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_opcode_i,
  input logic       sector_done_i,
  input logic       ready_o,
  input logic       spinning_o,
  input logic       not_ready_o
);
  localparam int unsigned IW = $clog2(SPINDOWN_CYC + 1) + 1;

  logic [IW-1:0] idle_cnt;
  logic          nonmedia;

  assign nonmedia = (cmd_opcode_i == 8'h00) || (cmd_opcode_i == 8'h03) ||
                    (cmd_opcode_i == 8'h15) || (cmd_opcode_i == 8'h1A) ||
                    (cmd_opcode_i == 8'h55) || (cmd_opcode_i == 8'h5A);

  always_ff @(posedge clk) begin
    if (rst || !ready_o || sector_done_i) idle_cnt <= '0;
    else                                  idle_cnt <= idle_cnt + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ready_o && !spinning_o));

  assert_insert_settle_R3: assert property (@(posedge clk) disable iff (rst)
    media_insert_i |=> (!spinning_o && !ready_o));

  assert_rise_from_spinup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(spinning_o));

  assert_spinup_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (spinning_o && !ready_o && cmd_valid_i && !nonmedia) |-> not_ready_o);

  assert_nonmedia_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && nonmedia) |-> !not_ready_o);

  assert_ready_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && cmd_valid_i) |-> !not_ready_o);

  assert_sector_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (ready_o && sector_done_i && !media_insert_i) |=> ready_o);

  assert_idle_window_R9: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (idle_cnt < IW'(SPINDOWN_CYC)));

  assert_ready_motor_R4: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> spinning_o);
endmodule

bind spindle_ctrl spindle_ctrl_chk #(.SPINDOWN_CYC(SPINDOWN_CYC)) u_chk (
  .clk(clk), .rst(rst), .media_insert_i(media_insert_i), .cmd_valid_i(cmd_valid_i),
  .cmd_opcode_i(cmd_opcode_i), .sector_done_i(sector_done_i), .ready_o(ready_o),
  .spinning_o(spinning_o), .not_ready_o(not_ready_o)
);

// File: tb/tb_spindle_ctrl.sv
module tb_spindle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_INS  = 3;
  localparam int T_UP   = 4;
  localparam int T_DOWN = 6;
  localparam int NVEC   = 28;

  // {insert, cmd_valid, opcode, sector, exp_ready, exp_spinning, exp_not_ready, req}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0,1'b1,8'h28,1'b0,3'b001,4'd2},  // 0  R2 no media
    {1'b0,1'b1,8'h00,1'b0,3'b000,4'd6},  // 1  R6
    {1'b1,1'b0,8'h00,1'b0,3'b000,4'd3},  // 2  R3 insert
    {1'b0,1'b1,8'h28,1'b0,3'b001,4'd5},  // 3  R5 settle
    {1'b0,1'b1,8'h03,1'b0,3'b000,4'd6},  // 4  R6
    {1'b0,1'b0,8'h00,1'b0,3'b000,4'd3},  // 5  R3
    {1'b0,1'b1,8'h28,1'b0,3'b011,4'd5},  // 6  R5 spin-up
    {1'b0,1'b0,8'h00,1'b1,3'b010,4'd10}, // 7  R10
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd4},  // 8  R4
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd4},  // 9  R4
    {1'b0,1'b1,8'h28,1'b0,3'b110,4'd8},  // 10 R8
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd8},  // 11 R8
    {1'b0,1'b0,8'h00,1'b1,3'b110,4'd9},  // 12 R9 sector
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 13
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 14
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 15
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 16
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 17
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd9},  // 18
    {1'b0,1'b1,8'h1A,1'b0,3'b000,4'd9},  // 19 R9 dropped
    {1'b0,1'b1,8'h5A,1'b0,3'b000,4'd6},  // 20 R6
    {1'b0,1'b0,8'h00,1'b0,3'b000,4'd6},  // 21 R6 not woken
    {1'b0,1'b1,8'h28,1'b0,3'b001,4'd7},  // 22 R7 wake
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd7},  // 23 R7
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd4},  // 24 R4
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd4},  // 25
    {1'b0,1'b0,8'h00,1'b0,3'b010,4'd4},  // 26
    {1'b0,1'b0,8'h00,1'b0,3'b110,4'd4}   // 27
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ins = 1'b0, cv = 1'b0, sec = 1'b0;
  logic [7:0] op = 8'h00;
  logic ready, spinning, nready;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spindle_ctrl #(.INSERT_CYC(T_INS), .SPINUP_CYC(T_UP), .SPINDOWN_CYC(T_DOWN)) dut (
    .clk(clk), .rst(rst), .media_insert_i(ins), .cmd_valid_i(cv), .cmd_opcode_i(op),
    .sector_done_i(sec), .ready_o(ready), .spinning_o(spinning), .not_ready_o(nready)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic drive(input logic i, input logic c, input logic [7:0] o, input logic s);
    @(negedge clk);
    ins = i; cv = c; op = o; sec = s;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(ready, 1'b0, "R1", "ready after reset");
    check(spinning, 1'b0, "R1", "spinning after reset");

    for (int k = 0; k < NVEC; k++) begin
      string tag;
      drive(VEC[k][17], VEC[k][16], VEC[k][15:8], VEC[k][7]);
      tag = $sformatf("R%0d", VEC[k][3:0]);
      check(ready,    VEC[k][6], tag, $sformatf("ready vec %0d", k));
      check(spinning, VEC[k][5], tag, $sformatf("spinning vec %0d", k));
      check(nready,   VEC[k][4], tag, $sformatf("not_ready vec %0d", k));
    end

    // R8: commands alone do not extend the spinning window
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1, 8'h28, 1'b0);
      check(nready, 1'b0, "R8", "not_ready while ready");
    end
    idle(); check(ready, 1'b1, "R8", "last spinning cycle");
    idle(); check(ready, 1'b0, "R8", "dropped without sector");

    // R6 / R7: mode opcodes do not wake, media opcode does
    drive(1'b0, 1'b1, 8'h15, 1'b0); check(nready, 1'b0, "R6", "mode select 6");
    drive(1'b0, 1'b1, 8'h55, 1'b0); check(nready, 1'b0, "R6", "mode select 10");
    idle(); check(spinning, 1'b0, "R6", "motor after mode cmds");
    drive(1'b0, 1'b1, 8'h43, 1'b0); check(nready, 1'b1, "R7", "media cmd while down");
    idle(); check(spinning, 1'b1, "R7", "spin-up started");
    repeat (3) idle();
    check(ready, 1'b0, "R4", "still spinning up");
    idle(); check(ready, 1'b1, "R4", "ready after spin-up");

    // R9: repeated sectors keep it spinning
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b0, 8'h00, 1'b1);
      for (int j = 0; j < 5; j++) begin
        idle(); check(ready, 1'b1, "R9", "kept alive by sectors");
      end
    end
    idle(); check(ready, 1'b1, "R9", "final window cycle");
    idle(); check(ready, 1'b0, "R9", "spun down after window");
    check(spinning, 1'b0, "R9", "motor off after window");

    // R11 / R3: insertion beats sector and command
    drive(1'b0, 1'b1, 8'h28, 1'b0);
    repeat (4) idle();
    idle(); check(ready, 1'b1, "R4", "ready before collision");
    drive(1'b1, 1'b1, 8'h28, 1'b1); check(nready, 1'b0, "R11", "cmd while ready");
    idle(); check(ready, 1'b0, "R11", "insert wins over sector");
    check(spinning, 1'b0, "R11", "motor off in settle");
    idle(); idle(); check(spinning, 1'b0, "R3", "settle last cycle");
    idle(); check(spinning, 1'b1, "R3", "spin-up after settle");

    // R1: reset mid-operation clears media
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check(spinning, 1'b0, "R1", "motor off after reset");
    drive(1'b0, 1'b1, 8'h28, 1'b0); check(nready, 1'b1, "R1", "no media after reset");
    idle(); check(spinning, 1'b0, "R1", "no wake without media");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule